// File: doc/BRIEF.md
# Twelve-Round 320-bit Sponge Permutation Core

This block applies a fixed-length permutation to a 320-bit state. The state is five 64-bit lanes. Each round adds a one-byte round constant to the middle lane. It then applies a 5-bit nonlinear substitution to all 64 bit columns at once. Last, each lane is mixed with two rotated copies of itself. The core computes one round per clock. A full pass takes exactly twelve clock cycles whatever the data, so the time spent on a state reveals nothing about its value.

The host drives a 320-bit word and pulses a one-cycle load strobe. Twelve clock cycles later a registered completion flag rises and the permuted state sits on the output bus. The flag and the state stay put until the next load. A new load at any time abandons the pass in progress and starts over with the new word. Padding, key and nonce handling and the mode built around the permutation belong to surrounding logic.

Top module: `perm_core`

## Requirements
- R1: A synchronous active-high reset clears the output state to all zeros and the completion flag to 0, also when it arrives during a pass; no completion follows a reset until a new load.
- R2: Lane x0 is bits 319:256 of the state bus, x1 is 255:192, x2 is 191:128, x3 is 127:64 and x4 is 63:0, on both the input and the output.
- R3: Each round XORs its constant into bits 7:0 of x2. It then applies the 5-bit substitution to every bit column, with x0 as the most significant bit of the column. Last it replaces every lane by itself XOR two right rotations: x0 by 19 and 28, x1 by 61 and 39, x2 by 1 and 6, x3 by 10 and 17, x4 by 7 and 41.
- R4: The twelve round constants, in order, are 0xF0, 0xE1, 0xD2, 0xC3, 0xB4, 0xA5, 0x96, 0x87, 0x78, 0x69, 0x5A, 0x4B; each is the previous one minus 0x0F.
- R5: The completion flag is 0 during the 12th clock cycle after the load edge and 1 from the 12th rising edge after it, for every input value; the output then equals the 12-round permutation of the loaded word.
- R6: Once the completion flag is high, it and the output state hold their values until the next load.
- R7: A load during a pass discards that pass; completion comes 12 edges after the new load with the permutation of the new word.
- R8: A load while the completion flag is high drives the flag to 0 at that edge and starts a new pass.
- R9: The state input is ignored while the load strobe is low; changing it in the middle of a pass does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures state_in and starts a pass |
| state_in | input | 320 | State to be permuted, x0 in the top 64 bits |
| state_out | output | 320 | Registered state, final once done is high |
| done | output | 1 | Registered flag, high while state_out holds a finished result |

## Verification
The bench compares several input words against a model of the permutation. The model uses a 32-entry substitution table rather than word-wide logic equations. A wrong rotation, a swapped lane order or a wrong constant schedule therefore shows up as a result mismatch. It probes the flag one cycle before and at the expected completion edge, which exposes a counter that stops early or late. It reloads in the middle of a pass and again right after completion. A core that finished the stale pass, or kept the flag high across a reload, would fail there. It also changes the input bus during a pass and resets during a pass. This catches a core that re-reads the bus or keeps counting after reset.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int unsigned LANE_W     = 64;
  localparam int unsigned LANE_N     = 5;
  localparam int unsigned STATE_W    = LANE_W * LANE_N;
  localparam int unsigned RC_TABLE_N = 12;
  localparam int unsigned RC_W       = 8;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LANE_N-1:0][LANE_W-1:0] lanes_t;

  // first rotation distance of the diffusion step, per lane
  function automatic int unsigned rot_first(input int unsigned lane);
    case (lane)
      0:       return 19;
      1:       return 61;
      2:       return 1;
      3:       return 10;
      default: return 7;
    endcase
  endfunction

  // second rotation distance of the diffusion step, per lane
  function automatic int unsigned rot_second(input int unsigned lane);
    case (lane)
      0:       return 28;
      1:       return 39;
      2:       return 6;
      3:       return 17;
      default: return 41;
    endcase
  endfunction

  function automatic lane_t ror(input lane_t w, input int unsigned n);
    return (w >> n) | (w << (LANE_W - n));
  endfunction
endpackage

// File: rtl/perm_rc.sv
module perm_rc #(
  parameter int unsigned ROUNDS = 12,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [CNT_W-1:0]          round_idx,
  output logic [perm_pkg::RC_W-1:0] rc
);
  // a shortened pass uses the tail of the constant schedule
  localparam int unsigned FIRST = perm_pkg::RC_TABLE_N - ROUNDS;

  logic [3:0] slot;

  always_comb begin
    slot = 4'(FIRST) + 4'(round_idx);
    rc   = {~slot, slot};
  end
endmodule

// File: rtl/perm_sbox.sv
module perm_sbox (
  input  perm_pkg::lanes_t x_in,
  output perm_pkg::lanes_t x_out
);
  import perm_pkg::*;

  lane_t a0, a1, a2, a3, a4;
  lane_t t0, t1, t2, t3, t4;

  always_comb begin
    a0 = x_in[0] ^ x_in[4];
    a1 = x_in[1];
    a2 = x_in[2] ^ x_in[1];
    a3 = x_in[3];
    a4 = x_in[4] ^ x_in[3];
    t0 = ~a0 & a1;
    t1 = ~a1 & a2;
    t2 = ~a2 & a3;
    t3 = ~a3 & a4;
    t4 = ~a4 & a0;
    a0 = a0 ^ t1;
    a1 = a1 ^ t2;
    a2 = a2 ^ t3;
    a3 = a3 ^ t4;
    a4 = a4 ^ t0;
    x_out[0] = a0 ^ a4;
    x_out[1] = a1 ^ a0;
    x_out[2] = ~a2;
    x_out[3] = a3 ^ a2;
    x_out[4] = a4;
  end
endmodule

// File: rtl/perm_diffuse.sv
module perm_diffuse (
  input  perm_pkg::lanes_t x_in,
  output perm_pkg::lanes_t x_out
);
  import perm_pkg::*;

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    localparam int unsigned ROT_A = rot_first(i);
    localparam int unsigned ROT_B = rot_second(i);
    assign x_out[i] = x_in[i] ^ ror(x_in[i], ROT_A) ^ ror(x_in[i], ROT_B);
  end
endmodule

// File: rtl/perm_seq.sv
module perm_seq #(
  parameter int unsigned ROUNDS = 12,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  output logic             step,
  output logic [CNT_W-1:0] round_idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic busy;

  assign step = busy && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      round_idx <= '0;
      done      <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      round_idx <= '0;
      done      <= 1'b0;
    end else if (busy) begin
      if (round_idx == LAST) begin
        busy      <= 1'b0;
        round_idx <= '0;
        done      <= 1'b1;
      end else begin
        round_idx <= round_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/perm_core.sv
module perm_core #(
  parameter int unsigned ROUNDS = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [perm_pkg::STATE_W-1:0] state_in,
  output logic [perm_pkg::STATE_W-1:0] state_out,
  output logic                         done
);
  import perm_pkg::*;

  localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_nxt;
  lanes_t             lanes_cur;
  lanes_t             lanes_rc;
  lanes_t             lanes_sb;
  lanes_t             lanes_dif;
  logic [RC_W-1:0]    rc;
  logic [CNT_W-1:0]   round_idx;
  logic               step;

  // x0 occupies the most significant lane of the bus
  for (genvar i = 0; i < LANE_N; i++) begin : g_map
    assign lanes_cur[i] = state_q[STATE_W-1-i*LANE_W -: LANE_W];
    assign state_nxt[STATE_W-1-i*LANE_W -: LANE_W] = lanes_dif[i];
  end

  perm_seq #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst(rst), .load(load),
    .step(step), .round_idx(round_idx), .done(done)
  );

  perm_rc #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) i_rc (
    .round_idx(round_idx), .rc(rc)
  );

  always_comb begin
    lanes_rc          = lanes_cur;
    lanes_rc[2][RC_W-1:0] = lanes_cur[2][RC_W-1:0] ^ rc;
  end

  perm_sbox i_sbox (.x_in(lanes_rc), .x_out(lanes_sb));

  perm_diffuse i_dif (.x_in(lanes_sb), .x_out(lanes_dif));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (load) begin
      state_q <= state_in;
    end else if (step) begin
      state_q <= state_nxt;
    end
  end

  assign state_out = state_q;
endmodule

// File: rtl/perm_core_chk.sv
module perm_core_chk #(
  parameter int unsigned ROUNDS = 12
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         load,
  input logic                         done,
  input logic [perm_pkg::STATE_W-1:0] state_out
);
  localparam int unsigned GAP_W = $clog2(ROUNDS + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(ROUNDS + 1);

  logic [GAP_W-1:0] gap;
  logic             armed;

  // edges since the last load, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      gap   <= '0;
      armed <= 1'b1;
    end else if (gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && state_out == '0));

  assert_fixed_latency_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (armed && gap == GAP_W'(ROUNDS)));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(state_out)));

  assert_load_clears_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> !done);
endmodule

bind perm_core perm_core_chk #(.ROUNDS(ROUNDS)) i_perm_core_chk (
  .clk(clk), .rst(rst), .load(load), .done(done), .state_out(state_out)
);

// File: tb/test_perm_core.sv
module test_perm_core;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 320;
  localparam int NVEC = 5;

  localparam logic [SW-1:0] VEC [NVEC] = '{
    320'h0,
    {5{64'hFFFF_FFFF_FFFF_FFFF}},
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978,
     64'h8796_A5B4_C3D2_E1F0, 64'h5555_AAAA_3333_CCCC},
    {64'h8000_0000_0000_0000, 256'h0},
    {256'h0, 64'h0000_0000_0000_0001}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [SW-1:0] state_in = '0;
  logic [SW-1:0] state_out;
  logic          done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_core i_perm_core (
    .clk(clk), .rst(rst), .load(load),
    .state_in(state_in), .state_out(state_out), .done(done)
  );

  function automatic logic [4:0] sb(input logic [4:0] v);
    case (v)
      5'd0:  return 5'h04; 5'd1:  return 5'h0b; 5'd2:  return 5'h1f; 5'd3:  return 5'h14;
      5'd4:  return 5'h1a; 5'd5:  return 5'h15; 5'd6:  return 5'h09; 5'd7:  return 5'h02;
      5'd8:  return 5'h1b; 5'd9:  return 5'h05; 5'd10: return 5'h08; 5'd11: return 5'h12;
      5'd12: return 5'h1d; 5'd13: return 5'h03; 5'd14: return 5'h06; 5'd15: return 5'h1c;
      5'd16: return 5'h1e; 5'd17: return 5'h13; 5'd18: return 5'h07; 5'd19: return 5'h0e;
      5'd20: return 5'h00; 5'd21: return 5'h0d; 5'd22: return 5'h11; 5'd23: return 5'h18;
      5'd24: return 5'h10; 5'd25: return 5'h0c; 5'd26: return 5'h01; 5'd27: return 5'h19;
      5'd28: return 5'h16; 5'd29: return 5'h0a; 5'd30: return 5'h0f; default: return 5'h17;
    endcase
  endfunction

  function automatic logic [63:0] rr(input logic [63:0] w, input int n);
    logic [127:0] d;
    d = {w, w} >> n;
    return d[63:0];
  endfunction

  // reference: R2 lane order, R3 round body, R4 constant schedule
  function automatic logic [SW-1:0] model(input logic [SW-1:0] s);
    logic [63:0] x [5];
    logic [4:0]  c;
    for (int i = 0; i < 5; i++) x[i] = s[SW-1-64*i -: 64];
    for (int r = 0; r < 12; r++) begin
      x[2][7:0] = x[2][7:0] ^ (8'hF0 - 8'(r * 15));
      for (int b = 0; b < 64; b++) begin
        c = sb({x[0][b], x[1][b], x[2][b], x[3][b], x[4][b]});
        {x[0][b], x[1][b], x[2][b], x[3][b], x[4][b]} = c;
      end
      x[0] = x[0] ^ rr(x[0], 19) ^ rr(x[0], 28);
      x[1] = x[1] ^ rr(x[1], 61) ^ rr(x[1], 39);
      x[2] = x[2] ^ rr(x[2], 1)  ^ rr(x[2], 6);
      x[3] = x[3] ^ rr(x[3], 10) ^ rr(x[3], 17);
      x[4] = x[4] ^ rr(x[4], 7)  ^ rr(x[4], 41);
    end
    return {x[0], x[1], x[2], x[3], x[4]};
  endfunction

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns at the first falling edge after the capturing edge
  task automatic start_perm(input logic [SW-1:0] v);
    @(negedge clk);
    state_in = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    logic [SW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset state", state_out, '0);
    chk("R1 reset done", {319'b0, done}, '0);
    rst = 1'b0;

    // table walk: latency and result for each vector
    for (int k = 0; k < NVEC; k++) begin
      start_perm(VEC[k]);
      repeat (11) @(negedge clk);
      chk("R5 done low before edge 12", {319'b0, done}, '0);
      @(negedge clk);
      chk("R5 done at edge 12", {319'b0, done}, 1);
      chk("R2 R3 R4 permutation result", state_out, model(VEC[k]));
    end

    // R6: hold after completion
    held = state_out;
    repeat (5) @(negedge clk);
    chk("R6 done held", {319'b0, done}, 1);
    chk("R6 state held", state_out, held);

    // R8: reload while done
    start_perm(VEC[2]);
    chk("R8 done cleared by load", {319'b0, done}, '0);
    repeat (12) @(negedge clk);
    chk("R8 restarted result", state_out, model(VEC[2]));

    // R9: input bus changes mid-pass
    start_perm(VEC[3]);
    repeat (3) @(negedge clk);
    state_in = ~VEC[3];
    repeat (9) @(negedge clk);
    chk("R9 input ignored, done", {319'b0, done}, 1);
    chk("R9 input ignored, result", state_out, model(VEC[3]));

    // R7: load during a pass
    start_perm(VEC[1]);
    repeat (4) @(negedge clk);
    start_perm(VEC[4]);
    repeat (11) @(negedge clk);
    chk("R7 stale pass suppressed", {319'b0, done}, '0);
    @(negedge clk);
    chk("R7 done after reload", {319'b0, done}, 1);
    chk("R7 result of new word", state_out, model(VEC[4]));

    // R1: reset during a pass
    start_perm(VEC[2]);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-pass reset state", state_out, '0);
    repeat (15) @(negedge clk);
    chk("R1 no completion after reset", {319'b0, done}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule